// File: doc/BRIEF.md
# Multiplexed Calibrated Bank Thermometer

This block reads the temperature of eight power-transistor banks through one shared resistor-controlled oscillator. It drives a select code that routes one bank's sensing resistor to the oscillator at a time. It waits a fixed settle period after each change of select. It then counts the oscillator's rising edges over a gate window whose length is set in system clock cycles. The scan runs through all eight channels in a loop for as long as the enable input is high.

Each count goes into one of two per-channel register files, chosen by the mode input. In calibration mode the power devices are off and the count is kept as that channel's baseline. In measure mode the count is kept as the live value. After the last channel of each scan, the block publishes two results together with a one-cycle done strobe. The first is the per-channel difference between live and baseline counts. The second is the index of the channel with the largest difference. The resistor's coefficient makes a higher count mean a hotter bank, so that index names the hottest bank. A power stage can use it to thin out that bank's gate pulses.

Top module: `bank_thermo_scan`

## Requirements
- R1: `sel` steps through channels 0,1,...,7 and wraps to 0. Each channel occupies exactly SETTLE + W clock cycles, where W is the effective window, so a full scan takes 8*(SETTLE+W) cycles.
- R2: Oscillator edges that arrive during the first SETTLE cycles after a change of `sel` are not counted.
- R3: The oscillator input is synchronized into the clock domain, and only rising edges are counted. Over a W-cycle window, a steady oscillator with a period of P clock cycles, where P divides W, gives exactly W/P.
- R4: `win_len` sets the window length in clock cycles and is sampled as each channel's window opens. A value of 0 acts as 1.
- R5: While `cal_mode` is 1, each channel's count is written into that channel's baseline register, and the live registers are left unchanged.
- R6: While `cal_mode` is 0, each channel's count is written into that channel's live register. Channel i's delta is the live count minus the baseline count, reported on `delta_o[i*16 +: 16]`.
- R7: When the live count is below the baseline count, that channel's delta is 0.
- R8: `hot_idx` is the index of the largest published delta. On equal deltas the lowest index wins.
- R9: `done` is high for exactly one cycle per scan, after channel 7 has been captured. All deltas and `hot_idx` change in that same cycle and hold their values until the next strobe.
- R10: While `en` is 0, `sel` stays at 0, nothing is captured and `done` stays low. When `en` returns to 1, the scan restarts at channel 0.
- R11: After reset, `sel`, `hot_idx`, every delta and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run the scan while high |
| osc_in | input | 1 | Asynchronous oscillator output |
| cal_mode | input | 1 | 1 = store baseline counts, 0 = store live counts |
| win_len | input | WIN_W | Gate window length in clock cycles |
| sel | output | 3 | Channel select for the sensing multiplexer |
| delta_o | output | 8*16 | Published per-channel deltas, channel i in bits i*16 +: 16 |
| hot_idx | output | 3 | Channel with the largest delta |
| done | output | 1 | One-cycle strobe when a scan's results are published |

## Verification
A channel's count is final at the clock edge that closes its window, which is SETTLE+W cycles after `sel` moved to it. The published deltas and index appear two register stages later, in the same cycle as `done`. The bench therefore never samples at a fixed cycle offset. It waits for `done` at the falling edge and reads every result in that cycle. It then checks that `done` has fallen one cycle later and that the results are unchanged after a further idle stretch. Each scenario lets one full scan go by after it changes the mode, the window or the oscillator periods, and checks only the next scan. It also counts the cycles between two strobes, which must equal 8*(SETTLE+W). Bench oscillator periods always divide the window, so each count is exact whatever the phase.

// File: rtl/bts_pkg.sv
package bts_pkg;

    // Number of sensing channels and width of every count register.
    localparam int unsigned CH_NUM = 8;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned SEL_W  = $clog2(CH_NUM);

    typedef logic [CNT_W-1:0] count_t;
    typedef logic [SEL_W-1:0] chan_t;

    typedef enum logic {
        PH_SETTLE = 1'b0,
        PH_WINDOW = 1'b1
    } scan_phase_e;

    // One finished channel measurement, valid for a single cycle.
    typedef struct packed {
        logic   vld;
        chan_t  ch;
        count_t cnt;
    } capture_t;

    // Live minus baseline, floored at zero.
    function automatic count_t sat_diff(input count_t live, input count_t base);
        return (live > base) ? count_t'(live - base) : '0;
    endfunction

endpackage

// File: rtl/bts_edge_sync.sv
module bts_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic osc_async,
    output logic rise_o
);
    // Two synchronizing flops plus one history flop for edge detection.
    logic [2:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[1:0], osc_async};
    end

    assign rise_o = shreg[1] & ~shreg[2];

    // R3
    rise_no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/bts_scan_ctrl.sv
module bts_scan_ctrl
    import bts_pkg::*;
#(
    parameter int unsigned WIN_W  = 24,
    parameter int unsigned SETTLE = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             rise_i,
    input  logic [WIN_W-1:0] win_len_i,
    output chan_t            sel_o,
    output capture_t         cap_o
);
    localparam logic [WIN_W-1:0] SETTLE_LAST = WIN_W'(SETTLE - 1);
    localparam chan_t            CH_LAST     = chan_t'(CH_NUM - 1);

    scan_phase_e      phase_q;
    logic [WIN_W-1:0] timer_q;
    logic [WIN_W-1:0] win_lim_q;
    count_t           acc_q;
    count_t           acc_nxt;

    // Edge accumulation saturates instead of wrapping.
    always_comb begin
        acc_nxt = acc_q;
        if (rise_i && (acc_q != '1)) acc_nxt = acc_q + count_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase_q   <= PH_SETTLE;
            timer_q   <= '0;
            win_lim_q <= WIN_W'(1);
            acc_q     <= '0;
            sel_o     <= '0;
            cap_o     <= '0;
        end else begin
            cap_o.vld <= 1'b0;
            unique case (phase_q)
                PH_SETTLE: begin
                    if (timer_q == SETTLE_LAST) begin
                        phase_q   <= PH_WINDOW;
                        timer_q   <= '0;
                        acc_q     <= '0;
                        win_lim_q <= (win_len_i == '0) ? WIN_W'(1) : win_len_i;
                    end else begin
                        timer_q <= timer_q + WIN_W'(1);
                    end
                end
                PH_WINDOW: begin
                    if (timer_q == win_lim_q - WIN_W'(1)) begin
                        cap_o.vld <= 1'b1;
                        cap_o.ch  <= sel_o;
                        cap_o.cnt <= acc_nxt;
                        sel_o     <= (sel_o == CH_LAST) ? '0 : sel_o + chan_t'(1);
                        phase_q   <= PH_SETTLE;
                        timer_q   <= '0;
                    end else begin
                        timer_q <= timer_q + WIN_W'(1);
                        acc_q   <= acc_nxt;
                    end
                end
                default: phase_q <= PH_SETTLE;
            endcase
        end
    end

    // R1
    sel_order_chk: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && (sel_o != $past(sel_o))) |->
            (sel_o == chan_t'($past(sel_o) + 1'b1)));

    // R10
    idle_no_capture_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> (!cap_o.vld && (sel_o == '0)));

endmodule

// File: rtl/bts_rank.sv
module bts_rank
    import bts_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cal_i,
    input  capture_t                cap_i,
    output logic [CH_NUM*CNT_W-1:0] delta_o,
    output chan_t                   hot_o,
    output logic                    done_o
);
    localparam chan_t CH_LAST = chan_t'(CH_NUM - 1);

    count_t diff  [CH_NUM];
    count_t live  [CH_NUM];
    count_t pub_q [CH_NUM];
    logic   pend_q;
    chan_t  best;
    count_t best_val;

    // Per-channel baseline and live register files.
    for (genvar gi = 0; gi < CH_NUM; gi++) begin : g_ch
        count_t base_q, live_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q <= '0;
                live_q <= '0;
            end else if (cap_i.vld && (cap_i.ch == chan_t'(gi))) begin
                if (cal_i) base_q <= cap_i.cnt;
                else       live_q <= cap_i.cnt;
            end
        end
        assign diff[gi] = sat_diff(live_q, base_q);
        assign live[gi] = live_q;
        assign delta_o[gi*CNT_W +: CNT_W] = pub_q[gi];

        // R7
        delta_floor_chk: assert property (@(posedge clk) disable iff (rst)
            done_o |-> (pub_q[gi] <= live[gi]));

        // R8
        hot_max_chk: assert property (@(posedge clk) disable iff (rst)
            done_o |-> (pub_q[hot_o] >= pub_q[gi]));

        // R8
        hot_tie_chk: assert property (@(posedge clk) disable iff (rst)
            (done_o && (hot_o > chan_t'(gi))) |-> (pub_q[gi] < pub_q[hot_o]));
    end

    // Linear scan with strict compare: the lowest index keeps a tie.
    always_comb begin
        best     = '0;
        best_val = diff[0];
        for (int i = 1; i < CH_NUM; i++) begin
            if (diff[i] > best_val) begin
                best_val = diff[i];
                best     = chan_t'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            done_o <= 1'b0;
            hot_o  <= '0;
            for (int i = 0; i < CH_NUM; i++) pub_q[i] <= '0;
        end else begin
            pend_q <= cap_i.vld && (cap_i.ch == CH_LAST);
            done_o <= pend_q;
            if (pend_q) begin
                hot_o <= best;
                for (int i = 0; i < CH_NUM; i++) pub_q[i] <= diff[i];
            end
        end
    end

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(hot_o));

endmodule

// File: rtl/bank_thermo_scan.sv
module bank_thermo_scan
    import bts_pkg::*;
#(
    parameter int unsigned WIN_W  = 24,
    parameter int unsigned SETTLE = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    osc_in,
    input  logic                    cal_mode,
    input  logic [WIN_W-1:0]        win_len,
    output logic [SEL_W-1:0]        sel,
    output logic [CH_NUM*CNT_W-1:0] delta_o,
    output logic [SEL_W-1:0]        hot_idx,
    output logic                    done
);
    logic     rise;
    capture_t cap;
    chan_t    sel_int;
    chan_t    hot_int;

    bts_edge_sync u_sync (
        .clk       (clk),
        .rst       (rst),
        .osc_async (osc_in),
        .rise_o    (rise)
    );

    bts_scan_ctrl #(
        .WIN_W  (WIN_W),
        .SETTLE (SETTLE)
    ) u_scan (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .rise_i    (rise),
        .win_len_i (win_len),
        .sel_o     (sel_int),
        .cap_o     (cap)
    );

    bts_rank u_rank (
        .clk     (clk),
        .rst     (rst),
        .cal_i   (cal_mode),
        .cap_i   (cap),
        .delta_o (delta_o),
        .hot_o   (hot_int),
        .done_o  (done)
    );

    assign sel     = sel_int;
    assign hot_idx = hot_int;

endmodule

// File: tb/bank_thermo_scan_test.sv
module bank_thermo_scan_test;
    import bts_pkg::*;

    localparam int WIN_W  = 24;
    localparam int SETTLE = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic osc_in = 1'b0;
    logic cal_mode = 1'b0;
    logic [WIN_W-1:0] win_len = WIN_W'(60);
    logic [SEL_W-1:0] sel;
    logic [CH_NUM*CNT_W-1:0] delta_o;
    logic [SEL_W-1:0] hot_idx;
    logic done;

    int checks = 0;
    int errors = 0;
    int sel_bad = 0;
    int period_q [8];
    int base_cnt [8];

    always #2 clk = ~clk;

    bank_thermo_scan #(.WIN_W(WIN_W), .SETTLE(SETTLE)) uut (
        .clk(clk), .rst(rst), .en(en), .osc_in(osc_in), .cal_mode(cal_mode),
        .win_len(win_len), .sel(sel), .delta_o(delta_o), .hot_idx(hot_idx),
        .done(done)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int delta_of(input int i);
        return int'(delta_o[i*CNT_W +: CNT_W]);
    endfunction

    // Oscillator model: each channel has its own period in clock cycles,
    // restarting its phase when the select changes.
    initial begin
        int ph = 0;
        logic [SEL_W-1:0] gsel = '0;
        forever begin
            @(negedge clk);
            if (rst) begin
                ph = 0;
                osc_in = 1'b0;
            end else begin
                if (sel !== gsel) begin
                    gsel = sel;
                    ph = 0;
                end else begin
                    ph = (ph + 1) % period_q[sel];
                end
                osc_in = (ph < (period_q[sel] + 1) / 2);
            end
        end
    end

    // Select order monitor (R1).
    initial begin
        logic [SEL_W-1:0] prev_sel = '0;
        logic prev_en = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && en && prev_en && (sel != prev_sel) &&
                (sel != SEL_W'(prev_sel + 1'b1)))
                sel_bad++;
            prev_sel = sel;
            prev_en = en;
        end
    end

    // Returns the number of cycles until the next done strobe.
    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 20000);
    endtask

    task automatic set_periods(input int p[8]);
        for (int i = 0; i < 8; i++) period_q[i] = p[i];
    endtask

    task automatic cal_pass(input int w, input int p[8]);
        int n;
        win_len = WIN_W'(w);
        cal_mode = 1'b1;
        set_periods(p);
        wait_done(n);
        wait_done(n);
        check_eq("R1 R4 scan length in calibration", n, 8 * (SETTLE + (w == 0 ? 1 : w)));
        for (int i = 0; i < 8; i++) base_cnt[i] = w / p[i];
    endtask

    task automatic meas_pass(input string tag, input int w, input int p[8]);
        int n;
        int exp_d [8];
        int exp_hot;
        int hot_seen;
        int d_seen [8];
        cal_mode = 1'b0;
        win_len = WIN_W'(w);
        set_periods(p);
        wait_done(n);
        wait_done(n);
        check_eq({tag, " R1 R4 scan length"}, n, 8 * (SETTLE + w));
        exp_hot = 0;
        for (int i = 0; i < 8; i++) begin
            exp_d[i] = (w / p[i] > base_cnt[i]) ? (w / p[i] - base_cnt[i]) : 0;
            if (exp_d[i] > exp_d[exp_hot]) exp_hot = i;
        end
        for (int i = 0; i < 8; i++) begin
            d_seen[i] = delta_of(i);
            check_eq($sformatf("%s R2 R3 R6 R7 delta ch%0d", tag, i), d_seen[i], exp_d[i]);
        end
        hot_seen = int'(hot_idx);
        check_eq({tag, " R8 hottest index"}, hot_seen, exp_hot);
        @(negedge clk);
        check_eq({tag, " R9 done one cycle"}, int'(done), 0);
        repeat (100) @(negedge clk);
        check_eq({tag, " R9 index held"}, int'(hot_idx), hot_seen);
        check_eq({tag, " R9 delta held"}, delta_of(exp_hot), d_seen[exp_hot]);
    endtask

    task automatic test_reset();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R11 sel after reset", int'(sel), 0);
        check_eq("R11 done after reset", int'(done), 0);
        check_eq("R11 hot after reset", int'(hot_idx), 0);
        check_eq("R11 deltas after reset", (delta_o == '0) ? 1 : 0, 1);
    endtask

    task automatic test_idle();
        int seen = 0;
        int bad_sel = 0;
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 1200; i++) begin
            @(negedge clk);
            if (done) seen++;
            if (sel != '0) bad_sel++;
        end
        check_eq("R10 no done while disabled", seen, 0);
        check_eq("R10 sel held at 0 while disabled", bad_sel, 0);
        en = 1'b1;
        begin
            int n;
            wait_done(n);
            check_eq("R10 scan resumes after enable", int'(done), 1);
        end
    endtask

    task automatic test_zero_window();
        int n;
        cal_mode = 1'b1;
        win_len = '0;
        wait_done(n);
        wait_done(n);
        check_eq("R4 zero window acts as one cycle", n, 8 * (SETTLE + 1));
    endtask

    initial begin
        int wd = 0;
        for (int i = 0; i < 8; i++) period_q[i] = 12;
        forever begin
            @(negedge clk);
            wd++;
            if (wd >= 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        test_reset();
        test_idle();

        // Uniform baseline, one hot channel.
        cal_pass(60, '{12, 12, 12, 12, 12, 12, 12, 12});
        meas_pass("single", 60, '{6, 6, 6, 4, 6, 6, 6, 6});
        // Equal largest deltas on channels 2 and 5.
        meas_pass("tie", 60, '{6, 6, 3, 6, 6, 3, 6, 6});
        // Channel 0 below its baseline; fastest edges on channel 6.
        meas_pass("floor", 60, '{20, 6, 6, 6, 6, 6, 2, 6});
        // Uneven baseline: the highest raw count is not the hottest (R5).
        cal_pass(60, '{12, 3, 12, 12, 12, 12, 12, 12});
        meas_pass("baseline R5", 60, '{12, 3, 12, 12, 4, 12, 12, 12});
        // Shorter window.
        cal_pass(30, '{10, 10, 10, 10, 10, 10, 10, 10});
        meas_pass("short window", 30, '{5, 5, 5, 5, 5, 5, 5, 2});

        test_zero_window();

        check_eq("R1 select order", sel_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule